// File: doc/BRIEF.md
# Mux-Selected Bitwise Logic Unit

This block is one pipeline stage of a wide datapath that computes a bitwise logic function of two or three operands. Four source multiplexers, called X, Y, Z and W here, pick their inputs under a 9-bit select word. A 4-bit function code then chooses the operation. X and Z supply the main operands. Y supplies a constant of all zeros or all ones, or the third operand C. W must stay at zero for every logic operation. The Y constant changes the meaning of a function code. One code therefore gives XOR or XNOR, and another gives AND or OR, depending on the Y constant. When Y carries C, one code turns the unit into a three-input XOR.

Operands A, B and C are registered together with the select word and the function code in one input stage. The next enabled clock edge computes the result into the result register P. P is fed back as a source for X and Z, so the unit can chain operations on its own result. An illegal combination raises a registered error flag and leaves P untouched.

Top module: `logic_unit_stage`

## Requirements
- R1: A synchronous active-high `rst` clears `p` and `bad_mode` to 0. It also resets the staged controls to select word 0 with function code 1100. The first enabled edge after reset therefore yields `p` = 0 with `bad_mode` = 0.
- R2: Bits [1:0] of `opmode` pick the X source: 00 zero, 01 the concatenation {A,B} with A in the upper bits, 10 `p`, 11 C. Bits [6:4] pick the Z source: 001 `p`, 010 C, and every other code zero.
- R3: When bits [3:2] of `opmode` are 00 (Y all zeros), function codes 0100 and 0111 give X^Z, and 0101 and 0110 give ~(X^Z). Codes 1100, 1101, 1110 and 1111 give X&Z, X&~Z, ~(X&Z) and ~X|Z.
- R4: When bits [3:2] of `opmode` are 10 (Y all ones), function codes 0100 and 0111 give ~(X^Z), and 0101 and 0110 give X^Z. Codes 1100, 1101, 1110 and 1111 give X|Z, X|~Z, ~(X|Z) and ~X&Z.
- R5: When bits [3:2] of `opmode` are 11, Y carries C. Only function code 0100 is legal then, and it gives X^C^Z.
- R6: A vector is illegal if any of these holds: bits [8:7] are not 00, bits [3:2] are 01, bits [3:2] are 11 with a code other than 0100, or the code lies outside 0100–0111 and 1100–1111. An illegal vector sets `bad_mode` to 1 and leaves `p` unchanged.
- R7: A vector is sampled on an edge where `ce` is high. Its result and flag appear after the next edge where `ce` is high, so each result uses the controls sampled with its own operands. A legal result clears `bad_mode`.
- R8: While `ce` is low, neither the input stage nor `p` nor `bad_mode` changes, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for both stages |
| a | input | A_W (30) | Operand A, upper part of the X concatenation |
| b | input | B_W (18) | Operand B, lower part of the X concatenation |
| c | input | A_W+B_W (48) | Operand C |
| opmode | input | 9 | Source selects for W[8:7], Z[6:4], Y[3:2], X[1:0] |
| alumode | input | 4 | Logic function code |
| p | output | A_W+B_W (48) | Registered result, also the feedback source |
| bad_mode | output | 1 | Registered flag for an illegal select/code pair |

## Verification
The assertions check on every cycle that `p` stays steady while `bad_mode` is high and while `ce` is low. They also check that reset clears the outputs, and that a nonzero W select or an illegal code with C on Y raises the flag one enabled edge later. Only the bench's scenarios can show that each entry of both function tables gives the right bits, that the sources route correctly, and that feedback chains through `p`. Only they can show the three-input XOR result and the pairing of controls with operands across back-to-back and gapped vectors.

// File: rtl/logic_unit_stage.sv
module logic_unit_stage #(
  parameter int A_W = 30,
  parameter int B_W = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ce,
  input  logic [A_W-1:0]     a,
  input  logic [B_W-1:0]     b,
  input  logic [A_W+B_W-1:0] c,
  input  logic [8:0]         opmode,
  input  logic [3:0]         alumode,
  output logic [A_W+B_W-1:0] p,
  output logic               bad_mode
);
  localparam int P_W = A_W + B_W;
  localparam logic [3:0] XOR3_CODE = 4'b0100;
  localparam logic [3:0] RST_CODE  = 4'b1100;

  logic [A_W-1:0] a_q;
  logic [B_W-1:0] b_q;
  logic [P_W-1:0] c_q;
  logic [8:0]     op_q;
  logic [3:0]     alu_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      c_q   <= '0;
      op_q  <= '0;
      alu_q <= RST_CODE;
    end else if (ce) begin
      a_q   <= a;
      b_q   <= b;
      c_q   <= c;
      op_q  <= opmode;
      alu_q <= alumode;
    end
  end

  wire [1:0] x_sel = op_q[1:0];
  wire [1:0] y_sel = op_q[3:2];
  wire [2:0] z_sel = op_q[6:4];
  wire [1:0] w_sel = op_q[8:7];

  logic [P_W-1:0] x_mux, y_mux, z_mux;

  always_comb begin
    case (x_sel)
      2'b01:   x_mux = {a_q, b_q};
      2'b10:   x_mux = p;
      2'b11:   x_mux = c_q;
      default: x_mux = '0;
    endcase
    case (y_sel)
      2'b10:   y_mux = '1;
      2'b11:   y_mux = c_q;
      default: y_mux = '0;
    endcase
    case (z_sel)
      3'b001:  z_mux = p;
      3'b010:  z_mux = c_q;
      default: z_mux = '0;
    endcase
  end

  wire [P_W-1:0] z_adj    = z_mux ^ {P_W{alu_q[0]}};
  wire [P_W-1:0] gate_out = (y_sel == 2'b10) ? (x_mux | z_adj) : (x_mux & z_adj);
  wire [P_W-1:0] parity   = x_mux ^ y_mux ^ z_mux ^ {P_W{alu_q[1] ^ alu_q[0]}};
  wire [P_W-1:0] fn_out   = alu_q[3] ? (gate_out ^ {P_W{alu_q[1]}}) : parity;

  wire mode_ok = (w_sel == 2'b00) && (y_sel != 2'b01) && alu_q[2] &&
                 ((y_sel != 2'b11) || (alu_q == XOR3_CODE));

  always_ff @(posedge clk) begin
    if (rst) begin
      p        <= '0;
      bad_mode <= 1'b0;
    end else if (ce) begin
      bad_mode <= !mode_ok;
      if (mode_ok) p <= fn_out;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (p == '0 && !bad_mode));

  // R6
  hold_on_bad_chk: assert property (@(posedge clk) disable iff (rst)
    bad_mode |-> $stable(p));

  // R6
  w_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && w_sel != 2'b00) |=> bad_mode);

  // R5
  xor3_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && y_sel == 2'b11 && alu_q != XOR3_CODE) |=> bad_mode);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(ce) && !$past(rst)) |-> ($stable(p) && $stable(bad_mode)));
endmodule

// File: tb/logic_unit_stage_tb_top.sv
module logic_unit_stage_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int A_W = 30;
  localparam int B_W = 18;
  localparam int P_W = A_W + B_W;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           ce  = 1'b0;
  logic [A_W-1:0] a   = '0;
  logic [B_W-1:0] b   = '0;
  logic [P_W-1:0] c   = '0;
  logic [8:0]     opmode  = '0;
  logic [3:0]     alumode = '0;
  logic [P_W-1:0] p;
  logic           bad_mode;

  logic_unit_stage #(.A_W(A_W), .B_W(B_W)) dut_i (
    .clk(clk), .rst(rst), .ce(ce), .a(a), .b(b), .c(c),
    .opmode(opmode), .alumode(alumode), .p(p), .bad_mode(bad_mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [P_W-1:0] p;
    logic           bad;
    string          tag;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad_cnt = 0;
  bit done = 0;

  logic [A_W-1:0] s_a = '0;
  logic [B_W-1:0] s_b = '0;
  logic [P_W-1:0] s_c = '0;
  logic [8:0]     s_op = '0;
  logic [3:0]     s_alu = 4'b1100;
  logic [P_W-1:0] p_m = '0;
  logic           bad_m = 1'b0;

  task automatic evaluate();
    logic [P_W-1:0] xv, zv, r;
    logic ok;
    case (s_op[1:0])
      2'b00: xv = '0;
      2'b01: xv = {s_a, s_b};
      2'b10: xv = p_m;
      default: xv = s_c;
    endcase
    case (s_op[6:4])
      3'b001: zv = p_m;
      3'b010: zv = s_c;
      default: zv = '0;
    endcase
    ok = 1'b1;
    r = '0;
    case ({s_op[3:2], s_alu})
      6'b00_0100, 6'b00_0111: r = xv ^ zv;
      6'b00_0101, 6'b00_0110: r = ~(xv ^ zv);
      6'b00_1100: r = xv & zv;
      6'b00_1101: r = xv & ~zv;
      6'b00_1110: r = ~(xv & zv);
      6'b00_1111: r = ~xv | zv;
      6'b10_0100, 6'b10_0111: r = ~(xv ^ zv);
      6'b10_0101, 6'b10_0110: r = xv ^ zv;
      6'b10_1100: r = xv | zv;
      6'b10_1101: r = xv | ~zv;
      6'b10_1110: r = ~(xv | zv);
      6'b10_1111: r = ~xv & zv;
      6'b11_0100: r = xv ^ s_c ^ zv;
      default: ok = 1'b0;
    endcase
    if (s_op[8:7] != 2'b00) ok = 1'b0;
    if (ok) p_m = r;
    bad_m = !ok;
  endtask

  task automatic drive(input logic [8:0] op, input logic [3:0] alu,
                       input logic [A_W-1:0] av, input logic [B_W-1:0] bv,
                       input logic [P_W-1:0] cv, input string tag);
    exp_t e;
    @(negedge clk);
    ce = 1'b1; opmode = op; alumode = alu; a = av; b = bv; c = cv;
    evaluate();
    e.p = p_m; e.bad = bad_m; e.tag = tag;
    exp_q.push_back(e);
    s_op = op; s_alu = alu; s_a = av; s_b = bv; s_c = cv;
  endtask

  always @(posedge clk) begin
    if (!rst && ce) begin
      #1;
      if (exp_q.size() == 0) begin
        total++; bad_cnt++;
        $display("FAIL %s: unexpected result p=%h bad=%0b expected none", "R7", p, bad_mode);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        total++;
        if (p !== e.p || bad_mode !== e.bad) begin
          bad_cnt++;
          $display("FAIL %s: p=%h bad=%0b expected p=%h bad=%0b", e.tag, p, bad_mode, e.p, e.bad);
        end
      end
    end
  end

  task automatic direct_check(input string tag, input logic [P_W-1:0] ep, input logic eb);
    total++;
    if (p !== ep || bad_mode !== eb) begin
      bad_cnt++;
      $display("FAIL %s: p=%h bad=%0b expected p=%h bad=%0b", tag, p, bad_mode, ep, eb);
    end
  endtask

  localparam logic [A_W-1:0] AV = 30'h2345_6789;
  localparam logic [B_W-1:0] BV = 18'h2_ABCD;
  localparam logic [P_W-1:0] CV = 48'hF0F0_1234_ABCD;

  // opmode fields: W[8:7] Z[6:4] Y[3:2] X[1:0]
  localparam logic [8:0] OP_AB_C_Y0 = 9'b00_010_00_01;
  localparam logic [8:0] OP_AB_C_Y1 = 9'b00_010_10_01;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    direct_check("R1", '0, 1'b0);

    // R1: first result after reset uses reset controls
    drive(9'b00_000_00_01, 4'b0100, AV, BV, CV, "R2");
    // R2: load {A,B} into p, then pass through with Z=P
    drive(9'b00_001_00_00, 4'b0100, '0, '0, '0, "R1");
    drive(9'b00_010_00_11, 4'b0100, AV, BV, CV, "R2");
    drive(9'b00_111_00_10, 4'b0100, '0, '0, CV, "R2");
    // R3: Y zero table
    for (int k = 0; k < 8; k++)
      drive(OP_AB_C_Y0, {k[2], 1'b1, k[1:0]}, AV ^ k, BV, CV, "R3");
    // R4: Y ones table
    for (int k = 0; k < 8; k++)
      drive(OP_AB_C_Y1, {k[2], 1'b1, k[1:0]}, AV, BV ^ k, CV, "R4");
    // R2: feedback X=P, Z=C
    drive(9'b00_010_00_10, 4'b1111, '0, '0, CV, "R3");
    drive(9'b00_001_10_10, 4'b0101, '0, '0, CV, "R2");
    // R5: three-input xor
    drive(9'b00_001_11_01, 4'b0100, AV, BV, CV, "R3");
    drive(9'b00_010_11_10, 4'b0100, AV, BV, 48'h0123_4567_89AB, "R5");
    // R6: illegal vectors hold p
    drive(9'b00_010_11_01, 4'b0101, AV, BV, CV, "R5");
    drive(9'b01_010_00_01, 4'b0100, AV, BV, CV, "R6");
    drive(9'b00_010_01_01, 4'b1100, AV, BV, CV, "R6");
    drive(9'b00_010_00_01, 4'b0000, AV, BV, CV, "R6");
    drive(9'b00_010_00_01, 4'b1011, AV, BV, CV, "R6");
    drive(OP_AB_C_Y0, 4'b1100, AV, BV, CV, "R6");
    // R7: back-to-back alternation of controls
    drive(OP_AB_C_Y1, 4'b1100, AV, BV, CV, "R7");
    drive(OP_AB_C_Y0, 4'b1110, AV, ~BV, CV, "R7");
    drive(9'b10_010_00_01, 4'b0100, AV, BV, CV, "R7");
    drive(OP_AB_C_Y1, 4'b1111, ~AV, BV, CV, "R7");

    // R8: ce low with changing inputs
    @(negedge clk);
    ce = 1'b0; opmode = 9'b00_010_10_11; alumode = 4'b0101; a = '1; b = '1; c = '1;
    repeat (4) @(negedge clk);
    direct_check("R8", p_m, bad_m);
    drive(9'b00_001_00_00, 4'b0100, '0, '0, '0, "R8");
    drive(9'b00_001_00_00, 4'b0100, '0, '0, '0, "R8");
    @(negedge clk);
    ce = 1'b0;
    repeat (2) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad_cnt++;
      $display("FAIL %s: pending=%0d expected 0", "R7", exp_q.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad_cnt);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++; bad_cnt++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad_cnt);
      $finish;
    end
  end
endmodule